// File: doc/BRIEF.md
# Paired Count/Compare Timer

This block holds two count units of `W` bits each, each with its own compare register. A unit counts up on its count clock. When the count reaches the compare value, the next count clock reloads it to zero, latches a sticky request flag and, when enabled, inverts that unit's square-wave output. Each unit takes its count clock from one of two sources. The first is a divided copy of the system clock with four division ratios. The second is a pin watched for events, and this pin is brought into the clock domain and edge-detected inside the block.

A control bit joins the two units into one timer of twice the width. In that mode unit 0's settings drive both halves. The low half carries into the high half, and only a match of the full combined value raises a request. A unit can be started by software, or armed so that a rising edge on a shared trigger pin starts it.

Software reaches the block through a flat register port. Writes land on the rising clock edge, and reads return data in the same cycle from the address.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts read 0, every control, compare and status register reads 0, both square-wave outputs are low and both request outputs are low.
- R2: Control bits [2:1] (address 0 for unit 0, address 1 for unit 1) select the count clock when bit 3 is 0: 00 gives one count per cycle, 01 gives one count every 2 cycles, 10 gives one every 8 cycles and 11 gives one every 16 cycles. The first count lands that many cycles after the write that sets run (bit 0).
- R3: On a count clock where the count equals the compare register (address 2 or 3), the count reloads to 0 and the unit's flag (status address 6, bit 0 or bit 1) is set. A compare value C therefore gives a period of C+1 counts.
- R4: A flag stays set until a write to the status register puts 0 in its bit, and writing 1 leaves it unchanged. Status bits [3:2] are request enables, and `irq[i]` is high exactly while flag i and enable i are both set.
- R5: With control bit 6 set, the unit's `tgl_out` bit inverts on every match. Otherwise it holds its level.
- R6: With control bit 3 set, the unit counts edges of its `evt_in` bit. Bits [5:4] select the edge: 00 rising, 01 falling, 10 or 11 both. A pin change made before clock edge N is counted at edge N+2, so the new count is visible after the third edge.
- R7: While run (bit 0) is 0, the unit's count does not change.
- R8: Status bit 4 joins the units as {cnt1,cnt0}, driven by unit 0's clock, run and toggle settings. The low half wraps from all-ones to 0 and carries into the high half. When both halves equal their compare registers, the next count reloads both to 0 and sets flag 0 only. Flag 1 is never set in this mode.
- R9: With control bit 7 set, a rising edge on `trig_in` sets the unit's run bit. The run bit reads back 1 after the third clock edge following the pin change.
- R10: A write of any value to a count address (4 for unit 0, 5 for unit 1) clears that count to 0.
- R11: Control and compare registers read back the value written, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr`, same cycle |
| evt_in | input | 2 | Event pins, one per unit |
| trig_in | input | 1 | Shared start trigger pin |
| irq | output | 2 | Request outputs, one per unit |
| tgl_out | output | 2 | Square-wave outputs, one per unit |

## Verification
A register write takes effect at the edge that samples it. From that edge, an internally clocked unit reaches count k after k times its division ratio edges, and the reload and flag follow one further division period after the count equals the compare value. Event-pin changes and trigger-pin rises need three edges to reach the count or the run bit, and a triggered unit then adds its division ratio before its first count. The bench drives the pins on the falling clock edge and counts rising edges from the write or pin change. It samples half a cycle after the edge where the result is due, and in the event and trigger cases it also checks the cycle before, where the old value must still show.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTL_W  = 8;

  localparam logic [ADDR_W-1:0] RA_CTL0 = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CTL1 = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMP1 = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CNT0 = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CNT1 = 3'd5;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd6;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;

  // per-unit control word, bit 7 down to bit 0
  typedef struct packed {
    logic       trig_en;
    logic       tgl_en;
    logic [1:0] edge_sel;
    logic       ext;
    logic [1:0] clk_sel;
    logic       run;
  } ctl_t;

  function automatic logic [4:0] div_of(input logic [1:0] sel);
    logic [4:0] d;
    case (sel)
      2'b00:   d = 5'd1;
      2'b01:   d = 5'd2;
      2'b10:   d = 5'd8;
      default: d = 5'd16;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int PW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PW-1:0] div_q, div_d, last;

  always_comb begin
    last = PW'(div_of(sel) - 5'd1);
    tick = run && (div_q == last);
    if (!run || tick) div_d = '0;
    else              div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  import tmr_pkg::*;

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;
  logic            rise, fall;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
    rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         reload,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | tick;
    if (clr || reload) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter int PW     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [1:0]   evt_in,
  input  logic         trig_in,
  output logic [1:0]   irq,
  output logic [1:0]   tgl_out
);
  import tmr_pkg::*;

  localparam int           NCH  = 2;
  localparam logic [W-1:0] MAXV = '1;

  ctl_t         ctl_q [NCH];
  ctl_t         ctl_d [NCH];
  logic [W-1:0] cmp_q [NCH];
  logic [W-1:0] cnt_w [NCH];
  logic [NCH-1:0] ctl_en, cmp_en, clr;
  logic [NCH-1:0] flag_q, flag_d, ie_q, ie_d, tgl_q, tgl_d;
  logic           casc_q, casc_d, stat_we;
  logic [NCH-1:0] psc_tick, evt_hit, ch_tick, at_cmp;
  logic [NCH-1:0] cnt_tick, reload, match, run_v;
  logic           trig_hit, full, carry;

  // ---------------- per-unit clock sources and counters ----------------
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_presc #(.PW(PW)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctl_q[i].run & ~ctl_q[i].ext),
      .sel  (ctl_q[i].clk_sel),
      .tick (psc_tick[i])
    );

    tmr_sync_edge #(.STAGES(STAGES)) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (evt_in[i]),
      .sel  (ctl_q[i].edge_sel),
      .hit  (evt_hit[i])
    );

    tmr_cnt #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr[i]),
      .tick  (cnt_tick[i]),
      .reload(reload[i]),
      .cnt   (cnt_w[i])
    );

    assign run_v[i] = ctl_q[i].run;
  end

  tmr_sync_edge #(.STAGES(STAGES)) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (trig_in),
    .sel  (EDGE_RISE),
    .hit  (trig_hit)
  );

  // ---------------- count, match and cascade steering ----------------
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_tick[i] = ctl_q[i].run && (ctl_q[i].ext ? evt_hit[i] : psc_tick[i]);
      at_cmp[i]  = (cnt_w[i] == cmp_q[i]);
    end
    full  = at_cmp[0] && at_cmp[1];
    carry = full || (cnt_w[0] == MAXV);
    if (casc_q) begin
      match[0]    = ch_tick[0] && full;
      match[1]    = 1'b0;
      cnt_tick[0] = ch_tick[0];
      reload[0]   = ch_tick[0] && carry;
      cnt_tick[1] = ch_tick[0] && carry;
      reload[1]   = ch_tick[0] && full;
    end else begin
      match       = ch_tick & at_cmp;
      cnt_tick    = ch_tick;
      reload      = ch_tick & at_cmp;
    end
  end

  // ---------------- register write decode and next state ----------------
  always_comb begin
    clr[0]    = wr_en && (addr == RA_CNT0);
    clr[1]    = wr_en && (addr == RA_CNT1);
    cmp_en[0] = wr_en && (addr == RA_CMP0);
    cmp_en[1] = wr_en && (addr == RA_CMP1);
    stat_we   = wr_en && (addr == RA_STAT);
    for (int i = 0; i < NCH; i++) begin
      ctl_d[i]  = ctl_q[i];
      ctl_en[i] = 1'b0;
      if (wr_en && (addr == ((i == 0) ? RA_CTL0 : RA_CTL1))) begin
        ctl_d[i]  = ctl_t'(wdata[CTL_W-1:0]);
        ctl_en[i] = 1'b1;
      end
      if (ctl_q[i].trig_en && trig_hit) begin
        ctl_d[i].run = 1'b1;
        ctl_en[i]    = 1'b1;
      end
    end
    flag_d = (stat_we ? (flag_q & wdata[1:0]) : flag_q) | match;
    ie_d   = stat_we ? wdata[3:2] : ie_q;
    casc_d = stat_we ? wdata[4]   : casc_q;
    for (int i = 0; i < NCH; i++) begin
      tgl_d[i] = tgl_q[i] ^ (match[i] && ctl_q[i].tgl_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_q[i] <= '0;
        cmp_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ctl_en[i]) ctl_q[i] <= ctl_d[i];
        if (cmp_en[i]) cmp_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ie_q   <= '0;
      casc_q <= 1'b0;
      tgl_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      casc_q <= casc_d;
      tgl_q  <= tgl_d;
    end
  end

  // ---------------- read port and outputs ----------------
  always_comb begin
    case (addr)
      RA_CTL0: rdata = W'(ctl_q[0]);
      RA_CTL1: rdata = W'(ctl_q[1]);
      RA_CMP0: rdata = cmp_q[0];
      RA_CMP1: rdata = cmp_q[1];
      RA_CNT0: rdata = cnt_w[0];
      RA_CNT1: rdata = cnt_w[1];
      RA_STAT: rdata = W'({casc_q, ie_q, flag_q});
      default: rdata = '0;
    endcase
  end

  assign irq     = flag_q & ie_q;
  assign tgl_out = tgl_q;

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   tgl,
  input logic [1:0]   flag,
  input logic         casc,
  input logic [1:0]   run,
  input logic [1:0]   clr,
  input logic [1:0]   tick,
  input logic [1:0]   reload,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (tgl == 2'b00 && flag == 2'b00);
    end
  end

  // R5
  tgl_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl[0] != $past(tgl[0])) |-> flag[0]);

  // R5
  tgl1_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl[1] != $past(tgl[1])) |-> flag[1]);

  // R8
  casc_no_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[1]) |-> !$past(casc));

  // R7
  stop_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !clr[0]) |=> $stable(cnt0));

  // R7
  stop_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && !run[1] && !clr[1]) |=> $stable(cnt1));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[0] && !reload[0] && !clr[0]) |=> (cnt0 == W'($past(cnt0) + 1'b1)));

  // R3
  flag_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> $past(tick[0]));

endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tgl   (tgl_out),
  .flag  (flag_q),
  .casc  (casc_q),
  .run   (run_v),
  .clr   (clr),
  .tick  (cnt_tick),
  .reload(reload),
  .cnt0  (cnt_w[0]),
  .cnt1  (cnt_w[1])
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] evt_in;
  logic       trig_in;
  logic [1:0] irq;
  logic [1:0] tgl_out;

  int  checks;
  int  errors;
  bit  done;

  tmr_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_in(evt_in), .trig_in(trig_in), .irq(irq), .tgl_out(tgl_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt_in = '0; trig_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 tgl_out after reset", tgl_out, 0);
    chk("R1 irq after reset", irq, 0);

    // R2 / R3 prescale and compare sweep on unit 0
    for (int s = 0; s < 4; s++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int d;
        int cmpv;
        d    = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 8 : 16;
        cmpv = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd6, 8'h00);
        wr(3'd2, 8'(cmpv));
        wr(3'd0, 8'((s << 1) | 1));
        for (int k = 1; k <= cmpv; k++) begin
          edges(d);
          rd(3'd4, v);
          chk($sformatf("R2 sel %0d count %0d", s, k), v, k);
        end
        edges(d);
        rd(3'd4, v);
        chk($sformatf("R3 sel %0d cmp %0d reload", s, cmpv), v, 0);
        rd(3'd6, v);
        chk($sformatf("R3 sel %0d cmp %0d flag", s, cmpv), v[0], 1);
      end
    end

    // R4 flag retention and clear, request gating
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h01);
    rd(3'd6, v);
    chk("R4 flag kept without enable", v[0], 1);
    chk("R4 irq low without enable", irq[0], 0);
    wr(3'd6, 8'h05);
    rd(3'd6, v);
    chk("R4 flag kept by writing 1", v[0], 1);
    chk("R4 irq with enable", irq[0], 1);
    wr(3'd6, 8'h04);
    rd(3'd6, v);
    chk("R4 flag cleared by writing 0", v[0], 0);
    chk("R4 irq drops after clear", irq[0], 0);
    wr(3'd6, 8'h00);

    // R7 stopped unit holds, R10 count clear
    wr(3'd4, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h01);
    edges(10);
    rd(3'd4, v);
    chk("R2 free count after 10 cycles", v, 10);
    wr(3'd0, 8'h00);
    rd(3'd4, v);
    edges(20);
    rd(3'd4, v2);
    chk("R7 stopped count holds", v2, v);
    wr(3'd4, 8'h55);
    rd(3'd4, v);
    chk("R10 count cleared by write", v, 0);

    // R5 toggle output
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h41);
    edges(2);
    chk("R5 toggle after first match", tgl_out, 2'b01);
    edges(2);
    chk("R5 toggle after second match", tgl_out, 2'b00);
    edges(2);
    chk("R5 toggle after third match", tgl_out, 2'b01);
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h00);

    // R6 event counting on unit 1, each edge select
    for (int e = 0; e < 3; e++) begin
      int expc;
      expc = (e == 2) ? 6 : 3;
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h00);
      wr(3'd3, 8'hFF);
      wr(3'd1, 8'(8'h09 | (e << 4)));
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        evt_in[1] = 1'b1;
        edges(2);
        if (p == 0) begin
          rd(3'd5, v);
          chk($sformatf("R6 edge %0d not yet counted", e), v, 0);
        end
        edges(1);
        if (p == 0) begin
          rd(3'd5, v);
          chk($sformatf("R6 edge %0d after rise", e), v, (e == 1) ? 0 : 1);
        end
        edges(2);
        evt_in[1] = 1'b0;
        edges(4);
      end
      rd(3'd5, v);
      chk($sformatf("R6 edge %0d total", e), v, expc);
    end
    wr(3'd1, 8'h00);

    // R9 trigger start on unit 1
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h80);
    edges(3);
    rd(3'd1, v);
    chk("R9 armed but not running", v, 8'h80);
    @(negedge clk);
    trig_in = 1'b1;
    edges(2);
    rd(3'd1, v);
    chk("R9 run not yet set", v[0], 0);
    edges(1);
    rd(3'd1, v);
    chk("R9 run set by trigger", v, 8'h81);
    rd(3'd5, v);
    chk("R9 count before first tick", v, 0);
    edges(1);
    rd(3'd5, v);
    chk("R9 first count after trigger", v, 1);
    trig_in = 1'b0;
    wr(3'd1, 8'h00);

    // R8 joined 16-bit operation, compare 0x0102
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h14);
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h01);
    edges(255);
    rd(3'd4, v); chk("R8 low at 255", v, 8'hFF);
    rd(3'd5, v); chk("R8 high at 255", v, 0);
    edges(1);
    rd(3'd4, v); chk("R8 low wraps", v, 0);
    rd(3'd5, v); chk("R8 high takes carry", v, 1);
    edges(2);
    rd(3'd4, v); chk("R8 low at 258", v, 2);
    rd(3'd6, v); chk("R8 no flag before match", v[1:0], 0);
    edges(1);
    rd(3'd4, v); chk("R8 low reloads", v, 0);
    rd(3'd5, v); chk("R8 high reloads", v, 0);
    rd(3'd6, v); chk("R8 only flag0 set", v[1:0], 2'b01);
    chk("R8 irq0 only", irq, 2'b01);
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h00);

    // R11 readback
    wr(3'd1, 8'h5C);
    rd(3'd1, v); chk("R11 control readback", v, 8'h5C);
    wr(3'd3, 8'h9A);
    rd(3'd3, v); chk("R11 compare readback", v, 8'h9A);
    rd(3'd7, v); chk("R11 unused address", v, 0);
    wr(3'd1, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule